// File: doc/BRIEF.md
# Split-Register CCD Line Readout Sequencer

This block steps one horizontal line of a two-phase horizontal charge-transfer register that is built as two equal halves, each able to shift toward its own end. On an accepted start pulse it counts one sample per clock. It tags every sample as empty, dark (excluded or used for the zero level) or image. It also drives a pair of direction phases for each half. In single-output mode the whole line leaves through one end, chosen by a select input. In dual-output mode the halves shift apart, one toward each end, and each end delivers a shorter line.

While an image sample is on the outputs, the block forces the exposure-clear, vertical-transfer and line-flush strobes to zero so that these edges add no noise to the picture. The strobes follow their requests at all other times. The block sums the pixel values of the usable columns in the leading dark group, leaving out the edge column at each side, which catches stray light. It divides the sum to give a zero-level figure for each line and presents it with a one-cycle valid pulse when the line ends.

Top module: `ccd_line_seq`

## Requirements
- R1: While reset is high and after it is released, sample_valid, dark_valid and the gated strobes are 0, sample_tag is 00, and both phase pairs are 10.
- R2: A line_start accepted at a clock edge makes sample_valid high from the next edge for exactly 2124 consecutive cycles in single-output mode, or 1068 in dual-output mode. A new line can be accepted at the edge that follows the last sample.
- R3: In single-output mode, sample k (from 0) is tagged as follows: 00 (empty) for k 0–11; 01 (dark, excluded) for k 12 and 39; 10 (dark, used) for k 13–38; 11 (image) for k 40–2095; 01 for k 2096 and 2123; 10 for k 2097–2122. An image sample is always followed by an image sample or an excluded dark sample.
- R4: In dual-output mode, sample k is tagged 00 for k 0–11, 01 for k 12 and 39, 10 for k 13–38, and 11 for k 40–1067.
- R5: Each phase pair is {H1,H2} in bits [1:0]. During a sample, a half that shifts toward the left output shows 10 on even k and 01 on odd k. A half that shifts toward the right output shows 01 on even k and 10 on odd k. In single-output mode, out_right=0 sends both halves left and out_right=1 sends both halves right. In dual-output mode, the left half shifts left and the right half shifts right.
- R6: When no sample is valid, both phase pairs hold the park value 10 and sample_tag is 00.
- R7: shut_o, vert_o and dump_o equal the requests sampled at the same edge that updates sample_tag. They are forced to 0 in every cycle in which sample_tag shows an image sample.
- R8: pix_in is taken in the cycle that shows its sample's tag. At the edge after the last sample of a line, dark_level becomes the floor of the sum of the 26 used leading-group dark samples divided by 26. At the same edge dark_valid pulses for one cycle, and dark_level holds that value until the next line ends.
- R9: A line_start pulse while a line is in progress, including during its last sample, has no effect. dual_mode and out_right are taken only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Request to begin a line |
| dual_mode | input | 1 | 1 selects dual-output operation |
| out_right | input | 1 | Single-output mode: 1 sends the line to the right end |
| shut_req | input | 1 | Exposure-clear strobe request |
| vert_req | input | VPH (2) | Vertical-transfer phase requests |
| dump_req | input | 1 | Line-flush strobe request |
| pix_in | input | PIX_W (12) | Digitised value of the sample shown on sample_tag |
| sample_valid | output | 1 | A line sample is on the outputs |
| sample_tag | output | 2 | Sample class code |
| hl_ph | output | 2 | Left-half {H1,H2} direction phases |
| hr_ph | output | 2 | Right-half {H1,H2} direction phases |
| shut_o | output | 1 | Gated exposure-clear strobe |
| vert_o | output | VPH (2) | Gated vertical-transfer phases |
| dump_o | output | 1 | Gated line-flush strobe |
| dark_level | output | PIX_W (12) | Per-line zero level |
| dark_valid | output | 1 | One-cycle pulse when dark_level updates |

## Verification
The hardest case to reach from the ports is a start request that arrives exactly at the last sample of a line, while a line is still running. Here the request must be refused, and the next request one cycle later must start a line with no gap other than the single idle cycle. The stimulus holds line_start high through an entire single-output line, so it covers the refusal at the last-sample edge and the back-to-back restart in one run. Separate pulses in the middle of lines, together with mode changes, confirm that a running line keeps its length, its tag layout and its phase directions.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    TAG_EMPTY     = 2'b00,
    TAG_DARK_SKIP = 2'b01,
    TAG_DARK_USE  = 2'b10,
    TAG_IMAGE     = 2'b11
  } sample_tag_e;

  // {H1,H2} value while the register is parked
  localparam logic [1:0] PH_PARK = 2'b10;

endpackage

// File: rtl/ccd_line_ctrl.sv
module ccd_line_ctrl #(
  parameter int EMPTY_N = 12,
  parameter int DARK_N  = 28,
  parameter int IMAGE_N = 2056,
  localparam int LEN_S  = EMPTY_N + 2 * DARK_N + IMAGE_N,
  localparam int LEN_D  = EMPTY_N + DARK_N + IMAGE_N / 2,
  localparam int CW     = $clog2(LEN_S)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          dual_mode,
  input  logic          out_right,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic          dual_q,
  output logic          right_q,
  output logic          last,
  output logic          accept
);

  localparam logic [CW-1:0] END_S = CW'(LEN_S - 1);
  localparam logic [CW-1:0] END_D = CW'(LEN_D - 1);

  assign last   = run && (cnt == (dual_q ? END_D : END_S));
  assign accept = !run && line_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      dual_q  <= 1'b0;
      right_q <= 1'b0;
    end else if (accept) begin
      run     <= 1'b1;
      cnt     <= '0;
      dual_q  <= dual_mode;
      right_q <= out_right;
    end else if (last) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ccd_sample_class.sv
module ccd_sample_class
  import ccd_seq_pkg::*;
#(
  parameter int EMPTY_N = 12,
  parameter int DARK_N  = 28,
  parameter int IMAGE_N = 2056,
  localparam int LEN_S  = EMPTY_N + 2 * DARK_N + IMAGE_N,
  localparam int CW     = $clog2(LEN_S)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic          dual_q,
  input  logic          last,
  output logic          image_now,
  output logic [1:0]    tag_q,
  output logic          valid_q,
  output logic          lead_q,
  output logic          last_q
);

  localparam logic [CW-1:0] B_DARK  = CW'(EMPTY_N);
  localparam logic [CW-1:0] B_DLAST = CW'(EMPTY_N + DARK_N - 1);
  localparam logic [CW-1:0] B_IMG   = CW'(EMPTY_N + DARK_N);
  localparam logic [CW-1:0] B_TAIL  = CW'(EMPTY_N + DARK_N + IMAGE_N);
  localparam logic [CW-1:0] B_END   = CW'(LEN_S - 1);

  sample_tag_e tag_c;
  logic        lead_c;

  always_comb begin
    lead_c = 1'b0;
    if (cnt < B_DARK) begin
      tag_c = TAG_EMPTY;
    end else if (cnt < B_IMG) begin
      lead_c = 1'b1;
      tag_c  = (cnt == B_DARK || cnt == B_DLAST) ? TAG_DARK_SKIP : TAG_DARK_USE;
    end else if (dual_q || cnt < B_TAIL) begin
      tag_c = TAG_IMAGE;
    end else begin
      tag_c = (cnt == B_TAIL || cnt == B_END) ? TAG_DARK_SKIP : TAG_DARK_USE;
    end
  end

  assign image_now = run && (tag_c == TAG_IMAGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q   <= TAG_EMPTY;
      valid_q <= 1'b0;
      lead_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      tag_q   <= run ? tag_c : TAG_EMPTY;
      valid_q <= run;
      lead_q  <= run && lead_c;
      last_q  <= last;
    end
  end

endmodule

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen
  import ccd_seq_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       odd,
  input  logic       dual_q,
  input  logic       right_q,
  output logic [1:0] ph [HALVES]
);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    // dual mode: lower halves go left, upper halves go right
    localparam logic SPLIT_DIR = (h >= HALVES / 2);
    logic toward_right;
    assign toward_right = dual_q ? SPLIT_DIR : right_q;

    always_ff @(posedge clk) begin
      if (rst)       ph[h] <= PH_PARK;
      else if (!run) ph[h] <= PH_PARK;
      else           ph[h] <= (toward_right ^ odd) ? 2'b01 : 2'b10;
    end
  end

endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg #(
  parameter int PIX_W    = 12,
  parameter int DARK_USE = 26,
  localparam int SW      = PIX_W + $clog2(DARK_USE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             acc_en,
  input  logic             fin,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] dark_level,
  output logic             dark_valid
);

  logic [SW-1:0] sum;
  logic [SW-1:0] quot;

  assign quot = sum / SW'(DARK_USE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= '0;
    end else if (clear) begin
      sum <= '0;
    end else if (acc_en) begin
      sum <= sum + SW'(pix_in);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dark_level <= '0;
      dark_valid <= 1'b0;
    end else begin
      dark_valid <= fin;
      if (fin) dark_level <= quot[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int EMPTY_N = 12,
  parameter int DARK_N  = 28,
  parameter int IMAGE_N = 2056,
  parameter int PIX_W   = 12,
  parameter int VPH     = 2,
  localparam int LEN_S  = EMPTY_N + 2 * DARK_N + IMAGE_N,
  localparam int CW     = $clog2(LEN_S)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             dual_mode,
  input  logic             out_right,
  input  logic             shut_req,
  input  logic [VPH-1:0]   vert_req,
  input  logic             dump_req,
  input  logic [PIX_W-1:0] pix_in,
  output logic             sample_valid,
  output logic [1:0]       sample_tag,
  output logic [1:0]       hl_ph,
  output logic [1:0]       hr_ph,
  output logic             shut_o,
  output logic [VPH-1:0]   vert_o,
  output logic             dump_o,
  output logic [PIX_W-1:0] dark_level,
  output logic             dark_valid
);

  logic          run, dual_q, right_q, last, accept;
  logic [CW-1:0] cnt;
  logic          image_now, lead_q, last_q;
  logic [1:0]    ph [2];

  ccd_line_ctrl #(.EMPTY_N(EMPTY_N), .DARK_N(DARK_N), .IMAGE_N(IMAGE_N)) u_ctrl (
    .clk(clk), .rst(rst), .line_start(line_start), .dual_mode(dual_mode),
    .out_right(out_right), .run(run), .cnt(cnt), .dual_q(dual_q),
    .right_q(right_q), .last(last), .accept(accept)
  );

  ccd_sample_class #(.EMPTY_N(EMPTY_N), .DARK_N(DARK_N), .IMAGE_N(IMAGE_N)) u_class (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .dual_q(dual_q), .last(last),
    .image_now(image_now), .tag_q(sample_tag), .valid_q(sample_valid),
    .lead_q(lead_q), .last_q(last_q)
  );

  ccd_phase_gen #(.HALVES(2)) u_phase (
    .clk(clk), .rst(rst), .run(run), .odd(cnt[0]), .dual_q(dual_q),
    .right_q(right_q), .ph(ph)
  );

  assign hl_ph = ph[0];
  assign hr_ph = ph[1];

  ccd_dark_avg #(.PIX_W(PIX_W), .DARK_USE(DARK_N - 2)) u_dark (
    .clk(clk), .rst(rst), .clear(accept),
    .acc_en(sample_valid && sample_tag == TAG_DARK_USE && lead_q),
    .fin(sample_valid && last_q), .pix_in(pix_in),
    .dark_level(dark_level), .dark_valid(dark_valid)
  );

  // quiet the disturbing strobes while an image sample is shifted
  always_ff @(posedge clk) begin
    if (rst) begin
      shut_o <= 1'b0;
      vert_o <= '0;
      dump_o <= 1'b0;
    end else begin
      shut_o <= shut_req & ~image_now;
      vert_o <= vert_req & {VPH{~image_now}};
      dump_o <= dump_req & ~image_now;
    end
  end

endmodule

// File: rtl/ccd_line_seq_chk.sv
module ccd_line_seq_chk #(
  parameter int VPH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           sample_valid,
  input logic [1:0]     sample_tag,
  input logic [1:0]     hl_ph,
  input logic [1:0]     hr_ph,
  input logic           shut_o,
  input logic [VPH-1:0] vert_o,
  input logic           dump_o,
  input logic           dark_valid
);

  assert_idle_park_R6: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> (hl_ph == 2'b10 && hr_ph == 2'b10 && sample_tag == 2'b00));

  assert_phase_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> ($countones(hl_ph) == 1 && $countones(hr_ph) == 1));

  assert_phase_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    sample_valid && $past(sample_valid) |-> (hl_ph != $past(hl_ph) && hr_ph != $past(hr_ph)));

  assert_image_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && sample_tag == 2'b11) |-> (!shut_o && vert_o == '0 && !dump_o));

  assert_tag_order_R3: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $past(sample_valid) && $past(sample_tag) == 2'b11)
      |-> (sample_tag == 2'b11 || sample_tag == 2'b01));

  assert_dark_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    dark_valid |=> !dark_valid);

  assert_dark_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    dark_valid |-> (!sample_valid && $past(sample_valid)));

endmodule

bind ccd_line_seq ccd_line_seq_chk #(.VPH(VPH)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_tag(sample_tag),
  .hl_ph(hl_ph), .hr_ph(hr_ph), .shut_o(shut_o), .vert_o(vert_o),
  .dump_o(dump_o), .dark_valid(dark_valid)
);

// File: tb/test_ccd_line_seq.sv
`timescale 1ns/1ps
module test_ccd_line_seq;

  localparam int PIX_W = 12;
  localparam int VPH   = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             line_start = 1'b0;
  logic             dual_mode = 1'b0;
  logic             out_right = 1'b0;
  logic             shut_req = 1'b0;
  logic [VPH-1:0]   vert_req = '0;
  logic             dump_req = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic             sample_valid, shut_o, dump_o, dark_valid;
  logic [1:0]       sample_tag, hl_ph, hr_ph;
  logic [VPH-1:0]   vert_o;
  logic [PIX_W-1:0] dark_level;

  always #2.5 clk = ~clk;

  ccd_line_seq i_ccd_line_seq (
    .clk(clk), .rst(rst), .line_start(line_start), .dual_mode(dual_mode),
    .out_right(out_right), .shut_req(shut_req), .vert_req(vert_req),
    .dump_req(dump_req), .pix_in(pix_in), .sample_valid(sample_valid),
    .sample_tag(sample_tag), .hl_ph(hl_ph), .hr_ph(hr_ph), .shut_o(shut_o),
    .vert_o(vert_o), .dump_o(dump_o), .dark_level(dark_level),
    .dark_valid(dark_valid)
  );

  int nchk = 0, nfail = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int cls(int k, bit dual, output bit lead);
    lead = 0;
    if (k < 12) return 0;
    if (k < 40) begin lead = 1; return (k == 12 || k == 39) ? 1 : 2; end
    if (dual || k < 2096) return 3;
    return (k == 2096 || k == 2123) ? 1 : 2;
  endfunction

  function automatic int phv(bit toward_right, int k);
    return (((k % 2) == 0) ^ toward_right) ? 2 : 1;
  endfunction

  bit m_run = 0, m_dual = 0, m_right = 0;
  int m_cnt = 0, m_len = 0, sum = 0;
  int e_valid = 0, e_tag = 0, e_lead = 0, e_last = 0, e_hl = 2, e_hr = 2;
  int e_shut = 0, e_vert = 0, e_dump = 0, e_dlev = 0, e_dval = 0;
  int len_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_cnt = 0; sum = 0;
      e_valid = 0; e_tag = 0; e_lead = 0; e_last = 0; e_hl = 2; e_hr = 2;
      e_shut = 0; e_vert = 0; e_dump = 0; e_dlev = 0; e_dval = 0;
    end else begin
      bit ld;
      int t;
      e_dval = 0;
      if (e_valid != 0 && e_last != 0) begin e_dlev = sum / 26; e_dval = 1; end
      if (e_valid != 0 && e_tag == 2 && e_lead != 0) sum += int'(pix_in);
      t = cls(m_cnt, m_dual, ld);
      e_valid = m_run;
      e_tag   = m_run ? t : 0;
      e_lead  = m_run && ld;
      e_last  = m_run && (m_cnt == m_len - 1);
      if (m_run) begin
        e_hl = phv(m_dual ? 1'b0 : m_right, m_cnt);
        e_hr = phv(m_dual ? 1'b1 : m_right, m_cnt);
      end else begin
        e_hl = 2; e_hr = 2;
      end
      e_shut = (m_run && t == 3) ? 0 : int'(shut_req);
      e_vert = (m_run && t == 3) ? 0 : int'(vert_req);
      e_dump = (m_run && t == 3) ? 0 : int'(dump_req);
      if (!m_run) begin
        if (line_start) begin
          m_run = 1; m_cnt = 0; m_dual = dual_mode; m_right = out_right;
          m_len = dual_mode ? 1068 : 2124;
          sum = 0;
          len_q.push_back(m_len);
        end
      end else if (m_cnt == m_len - 1) begin
        m_run = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int run_len = 0;
  bit prev_valid = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 sample_valid", int'(sample_valid), e_valid);
      chk(m_dual ? "R4 sample_tag dual" : "R3 sample_tag single", int'(sample_tag), e_tag);
      chk(e_valid != 0 ? "R5 left phases" : "R6 left park", int'(hl_ph), e_hl);
      chk(e_valid != 0 ? "R5 right phases" : "R6 right park", int'(hr_ph), e_hr);
      chk("R7 shut_o", int'(shut_o), e_shut);
      chk("R7 vert_o", int'(vert_o), e_vert);
      chk("R7 dump_o", int'(dump_o), e_dump);
      chk("R8 dark_valid", int'(dark_valid), e_dval);
      chk("R8 dark_level", int'(dark_level), e_dlev);
      if (sample_valid) run_len++;
      if (prev_valid && !sample_valid) begin
        int exp_len;
        exp_len = (len_q.size() > 0) ? len_q.pop_front() : -1;
        chk("R9 line length unaffected by extra start", run_len, exp_len);
        run_len = 0;
      end
      prev_valid = sample_valid;
    end
  end

  // free-running data and strobe requests
  always @(negedge clk) begin
    pix_in   <= PIX_W'($urandom);
    shut_req <= 1'($urandom);
    vert_req <= VPH'($urandom);
    dump_req <= 1'($urandom);
  end

  task automatic start_line(bit d, bit r);
    dual_mode  = d;
    out_right  = r;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected<=60000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid in reset", int'(sample_valid), 0);
    chk("R1 tag in reset", int'(sample_tag), 0);
    chk("R1 left park in reset", int'(hl_ph), 2);
    chk("R1 right park in reset", int'(hr_ph), 2);
    chk("R1 strobes in reset", int'({shut_o, vert_o, dump_o}), 0);
    chk("R1 dark_valid in reset", int'(dark_valid), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // single left, with an ignored mid-line start that also changes mode (R9)
    start_line(0, 0);
    repeat (600) @(negedge clk);
    dual_mode = 1; out_right = 1; line_start = 1;
    @(negedge clk);
    line_start = 0;
    @(negedge clk);
    chk("R9 line still running after mid-line start", int'(sample_valid), 1);
    repeat (1600) @(negedge clk);

    // single right, mode toggled mid-line
    start_line(0, 1);
    repeat (200) @(negedge clk);
    dual_mode = 1; out_right = 0;
    repeat (2000) @(negedge clk);

    // dual, mode inputs changed after start
    start_line(1, 1);
    repeat (300) @(negedge clk);
    dual_mode = 0; out_right = 0;
    repeat (900) @(negedge clk);

    // start held high: refused at last-sample edge, then back-to-back line (R2, R9)
    dual_mode = 0; out_right = 0; line_start = 1;
    repeat (2130) @(negedge clk);
    line_start = 0;
    repeat (2200) @(negedge clk);

    // dual again, other select value
    start_line(1, 0);
    repeat (1200) @(negedge clk);

    chk("R2 all accepted lines completed", len_q.size(), 0);
    finish_run();
  end

endmodule